// File: doc/BRIEF.md
# Match-Compare Timer with Watchdog Channel

This block is a timer peripheral on a small synchronous register bus. A free-running up-counter advances once per clock. Six compare channels each hold a match value. When the counter equals a channel's match value, that channel sets a sticky status flag. The flag drives the channel's interrupt line when the matching enable bit is set. Software can also load the counter. It can freeze a copy of the count into a snapshot register and read it back as one consistent word.

The highest-numbered channel has a second role as a system watchdog. Software arms it by turning on watchdog mode and also setting that channel's interrupt enable. It then keeps pushing the channel's match value ahead of the counter, computing the next value as the current count plus a tick budget, modulo 2^32. If the counter ever catches up with the match value, the block emits a one-cycle reset request for the system reset logic.

Top module: `tick_match_wdog`

## Requirements
- R1: The counter increments by one every clock and wraps modulo 2^32. It reads at byte offset 0x00. A write to 0x00 loads the written value, and counting resumes from it on the next clock.
- R2: Channel i (i = 0..5) has a 32-bit read/write match register at byte offset 0x08 + 4*i, so channel 5 sits at 0x1C.
- R3: The status register is at offset 0x20, with bit i belonging to channel i. Bit i is set on the clock edge that sees the counter equal to match register i, and it stays set. Writing 1 to bit i clears it, and writing 0 leaves it unchanged.
- R4: The interrupt-enable register is at offset 0x24, with bits [5:0], one per channel. Output irq[i] equals status bit i AND enable bit i, registered, so it follows the status bit one clock later.
- R5: Writing a value with bit 0 set to offset 0x30 copies the counter value of that write cycle into the snapshot register, which reads at 0x34. Writing with bit 0 clear does not change the snapshot.
- R6: Compares are plain equality on the wrapped count. A match value computed as count plus ticks modulo 2^32 fires after exactly that many ticks, including across the wrap: a load of 0xFFFFFFF0 with match 0x00000010 fires 0x20 counts later.
- R7: Bit 0 of offset 0x28 is the watchdog mode enable. It is written and read at that offset.
- R8: With watchdog mode on and enable bit 5 set, wdog_rst_req goes high for exactly one clock, in the cycle after the counter equals match register 5.
- R9: wdog_rst_req stays low whenever watchdog mode is off or enable bit 5 is clear. It is therefore low from reset until software sets both.
- R10: Rewriting match register 5 to a later value before the counter reaches the old value suppresses the reset at the old value. The reset then occurs at the new value.
- R11: Synchronous reset clears every register to zero. Reads from unmapped or unaligned offsets return zero, and writes to them change nothing.
- R12: bus_rdata is registered. It shows the register addressed in the previous clock, sampled before any write on that same edge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 6 | Per-channel interrupt, status AND enable |
| wdog_rst_req | output | 1 | One-cycle system reset request from the watchdog channel |

## Verification
The compare path is driven with a counter loaded just below a target, a counter loaded just below the 2^32 wrap, and a channel whose status sets while its enable is clear. Together these separate a missing equality, an off-by-one in status and interrupt timing, and a bad enable gate. The watchdog is tried in four patterns: mode on with enable bit 5 clear, enable bit 5 set with mode off, both on, and both on with a refresh before the old match. These distinguish the two-input gating, the exact firing cycle and pulse width, and whether a refresh truly replaces the pending compare. Snapshot, unaligned and unmapped accesses confirm that only the intended registers move.

// File: rtl/tmw_pkg.sv
package tmw_pkg;

  // register byte offsets
  localparam int OFS_COUNT   = 'h00;
  localparam int OFS_MATCH0  = 'h08;
  localparam int OFS_STATUS  = 'h20;
  localparam int OFS_IRQEN   = 'h24;
  localparam int OFS_WDEN    = 'h28;
  localparam int OFS_SNAPCMD = 'h30;
  localparam int OFS_SNAP    = 'h34;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_MATCH,
    SEL_STATUS,
    SEL_IRQEN,
    SEL_WDEN,
    SEL_SNAPCMD,
    SEL_SNAP
  } reg_sel_e;

endpackage

// File: rtl/tmw_counter.sv
module tmw_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  input  logic          snap_en,
  output logic [DW-1:0] count,
  output logic [DW-1:0] snap
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load_en) begin
      count <= load_val;
    end else begin
      count <= count + DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
    end else if (snap_en) begin
      snap <= count;
    end
  end

endmodule

// File: rtl/tmw_channel.sv
module tmw_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          match_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] count,
  input  logic          clr,
  output logic [DW-1:0] match_q,
  output logic          status_q
);

  logic hit;
  assign hit = (count == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
    end else if (match_wr) begin
      match_q <= wdata;
    end
  end

  // a new hit wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | hit;
    end
  end

endmodule

// File: rtl/tmw_wdog.sv
module tmw_wdog #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_on,
  input  logic          irq_armed,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] limit,
  output logic          rst_req
);

  logic fire;
  assign fire = mode_on & irq_armed & (count == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req <= 1'b0;
    end else begin
      rst_req <= fire & ~rst_req;
    end
  end

endmodule

// File: rtl/tick_match_wdog.sv
module tick_match_wdog #(
  parameter int DW     = 32,
  parameter int NUM_CH = 6,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              wdog_rst_req
);
  import tmw_pkg::*;

  localparam int WD_CH     = NUM_CH - 1;
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int MATCH_END = OFS_MATCH0 + 4 * NUM_CH;

  reg_sel_e          sel;
  logic [CH_W-1:0]   ch_idx;
  logic [AW-1:0]     match_off;

  logic [DW-1:0]     count;
  logic [DW-1:0]     snap;
  logic [DW-1:0]     match_val [NUM_CH];
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] irq_en;
  logic              wd_en;

  logic              wr_count, wr_match, wr_status, wr_irqen, wr_wden, wr_snap;
  logic [NUM_CH-1:0] clr_mask;
  logic [DW-1:0]     rd_nxt;

  // address decode: aligned words only
  always_comb begin
    sel       = SEL_NONE;
    match_off = bus_addr - AW'(OFS_MATCH0);
    ch_idx    = CH_W'(match_off >> 2);
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr == AW'(OFS_COUNT))
        sel = SEL_COUNT;
      else if (bus_addr >= AW'(OFS_MATCH0) && bus_addr < AW'(MATCH_END))
        sel = SEL_MATCH;
      else if (bus_addr == AW'(OFS_STATUS))
        sel = SEL_STATUS;
      else if (bus_addr == AW'(OFS_IRQEN))
        sel = SEL_IRQEN;
      else if (bus_addr == AW'(OFS_WDEN))
        sel = SEL_WDEN;
      else if (bus_addr == AW'(OFS_SNAPCMD))
        sel = SEL_SNAPCMD;
      else if (bus_addr == AW'(OFS_SNAP))
        sel = SEL_SNAP;
    end
  end

  assign wr_count  = bus_we && (sel == SEL_COUNT);
  assign wr_match  = bus_we && (sel == SEL_MATCH);
  assign wr_status = bus_we && (sel == SEL_STATUS);
  assign wr_irqen  = bus_we && (sel == SEL_IRQEN);
  assign wr_wden   = bus_we && (sel == SEL_WDEN);
  assign wr_snap   = bus_we && (sel == SEL_SNAPCMD) && bus_wdata[0];
  assign clr_mask  = wr_status ? bus_wdata[NUM_CH-1:0] : '0;

  tmw_counter #(.DW(DW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_en  (wr_count),
    .load_val (bus_wdata),
    .snap_en  (wr_snap),
    .count    (count),
    .snap     (snap)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmw_channel #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .match_wr (wr_match && (ch_idx == CH_W'(g))),
      .wdata    (bus_wdata),
      .count    (count),
      .clr      (clr_mask[g]),
      .match_q  (match_val[g]),
      .status_q (status[g])
    );
  end

  tmw_wdog #(.DW(DW)) u_wd (
    .clk       (clk),
    .rst       (rst),
    .mode_on   (wd_en),
    .irq_armed (irq_en[WD_CH]),
    .count     (count),
    .limit     (match_val[WD_CH]),
    .rst_req   (wdog_rst_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en <= '0;
      wd_en  <= 1'b0;
    end else begin
      if (wr_irqen) irq_en <= bus_wdata[NUM_CH-1:0];
      if (wr_wden)  wd_en  <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= status & irq_en;
  end

  always_comb begin
    case (sel)
      SEL_COUNT:  rd_nxt = count;
      SEL_MATCH:  rd_nxt = match_val[ch_idx];
      SEL_STATUS: rd_nxt = DW'(status);
      SEL_IRQEN:  rd_nxt = DW'(irq_en);
      SEL_WDEN:   rd_nxt = DW'(wd_en);
      SEL_SNAP:   rd_nxt = snap;
      default:    rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nxt;
  end

endmodule

// File: rtl/tmw_checker.sv
module tmw_checker #(
  parameter int DW     = 32,
  parameter int NUM_CH = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [DW-1:0]     count,
  input logic              cnt_load,
  input logic              snap_en,
  input logic [DW-1:0]     snap,
  input logic [NUM_CH-1:0] status,
  input logic [NUM_CH-1:0] clr_mask,
  input logic [NUM_CH-1:0] irq_en,
  input logic [NUM_CH-1:0] irq,
  input logic              wd_en,
  input logic              rst_req
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1: free-running increment when not loaded
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(cnt_load)) |-> (count == $past(count) + DW'(1)));

  // R3: status bits only fall when software asked for it
  a_r3_status_sticky: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (($past(status) & ~status & ~$past(clr_mask)) == '0));

  // R4: no interrupt without its enable in the prior cycle
  a_r4_irq_gated: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ((irq & ~$past(irq_en)) == '0));

  // R5: snapshot takes the count of the command cycle
  a_r5_snap_capture: assert property (@(posedge clk) disable iff (rst)
    snap_en |=> (snap == $past(count)));

  // R8: reset request lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R9: reset request needs both mode and enable bit
  a_r9_needs_both: assert property (@(posedge clk) disable iff (rst)
    (past_ok && rst_req) |-> $past(wd_en && irq_en[NUM_CH-1]));

endmodule

bind tick_match_wdog tmw_checker #(.DW(DW), .NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .count    (count),
  .cnt_load (wr_count),
  .snap_en  (wr_snap),
  .snap     (snap),
  .status   (status),
  .clr_mask (clr_mask),
  .irq_en   (irq_en),
  .irq      (irq),
  .wd_en    (wd_en),
  .rst_req  (wdog_rst_req)
);

// File: tb/tb_tick_match_wdog.sv
module tb_tick_match_wdog;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  irq;
  logic        wdog_rst_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  tick_match_wdog dut (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq          (irq),
    .wdog_rst_req (wdog_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdog_rst_req) cnt++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    int p;
    rd(8'h24, v); chk("R11 irq enable after reset", v, 0);
    rd(8'h28, v); chk("R11 wd enable after reset", v, 0);
    rd(8'h08, v); chk("R11 match0 after reset", v, 0);
    rd(8'h1C, v); chk("R11 match5 after reset", v, 0);
    rd(8'h34, v); chk("R11 snapshot after reset", v, 0);
    chk("R11 irq after reset", {26'd0, irq}, 0);
    count_pulses(50, p);
    chk("R9 no reset request before enabling", p, 0);
  endtask

  task automatic t_counter();
    logic [31:0] v;
    wr(8'h00, 32'h0000_1000);
    rd(8'h00, v); chk("R1 R12 counter load readback", v, 32'h0000_1000);
    wr(8'h00, 32'hFFFF_FFFF);
    idle(2);
    rd(8'h00, v); chk("R1 counter wraps", v, 32'h0000_0001);
  endtask

  task automatic t_snapshot();
    logic [31:0] v;
    wr(8'h00, 32'h0000_2000);
    wr(8'h30, 32'h1);
    idle(5);
    rd(8'h34, v); chk("R5 snapshot value", v, 32'h0000_2000);
    rd(8'h00, v); chk("R5 counter kept running", v, 32'h0000_2007);
    wr(8'h30, 32'h0);
    rd(8'h34, v); chk("R5 write of 0 leaves snapshot", v, 32'h0000_2000);
    rd(8'h30, v); chk("R11 command offset reads zero", v, 0);
  endtask

  task automatic t_match_rw();
    logic [31:0] v;
    for (int i = 0; i < 6; i++) wr(8'(8 + 4 * i), 32'hA000_0000 + 32'(i) * 32'h111);
    for (int i = 0; i < 6; i++) begin
      rd(8'(8 + 4 * i), v);
      chk("R2 match register readback", v, 32'hA000_0000 + 32'(i) * 32'h111);
    end
  endtask

  task automatic t_status_irq();
    logic [31:0] v;
    wr(8'h24, 32'h01);
    wr(8'h08, 32'h0000_5005);
    wr(8'h10, 32'h0000_5006);
    wr(8'h20, 32'h3F);
    wr(8'h00, 32'h0000_5000);
    idle(5);
    chk("R4 irq not yet raised", {26'd0, irq}, 0);
    idle(3);
    chk("R4 irq only on enabled channel", {26'd0, irq}, 32'h01);
    rd(8'h20, v); chk("R3 status bits set", v, 32'h05);
    wr(8'h20, 32'h0);
    rd(8'h20, v); chk("R3 writing 0 keeps status", v, 32'h05);
    wr(8'h20, 32'h1);
    idle(1);
    chk("R4 irq drops after clear", {26'd0, irq}, 0);
    rd(8'h20, v); chk("R3 write 1 clears only that bit", v, 32'h04);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    logic [31:0] tgt;
    tgt = 32'hFFFF_FFF0 + 32'h20;
    wr(8'h24, 32'h02);
    wr(8'h0C, tgt);
    wr(8'h20, 32'h3F);
    wr(8'h00, 32'hFFFF_FFF0);
    idle(16);
    chk("R6 no match before wrap", {26'd0, irq}, 0);
    idle(32);
    chk("R6 match after wrap", {26'd0, irq}, 32'h02);
    rd(8'h20, v); chk("R6 status after wrap", v & 32'h02, 32'h02);
  endtask

  task automatic t_wdog_gate();
    logic [31:0] v;
    int p;
    wr(8'h24, 32'h00);
    wr(8'h28, 32'h1);
    rd(8'h28, v); chk("R7 wd enable readback", v, 1);
    wr(8'h1C, 32'h0000_6014);
    wr(8'h20, 32'h3F);
    wr(8'h00, 32'h0000_6000);
    count_pulses(40, p);
    chk("R9 mode on, enable bit 5 clear", p, 0);
    rd(8'h20, v); chk("R9 compare still happened", v & 32'h20, 32'h20);
    wr(8'h28, 32'h0);
    wr(8'h24, 32'h20);
    wr(8'h00, 32'h0000_6000);
    count_pulses(40, p);
    chk("R9 enable bit 5 set, mode off", p, 0);
  endtask

  task automatic t_wdog_fire();
    int first;
    int p;
    first = -1; p = 0;
    wr(8'h24, 32'h20);
    wr(8'h28, 32'h1);
    wr(8'h1C, 32'h0000_7014);
    wr(8'h00, 32'h0000_7000);
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (wdog_rst_req) begin
        p++;
        if (first < 0) first = i;
      end
    end
    chk("R8 reset request cycle", first, 21);
    chk("R8 single pulse", p, 1);
  endtask

  task automatic t_refresh();
    int p;
    int q;
    wr(8'h1C, 32'h0000_8020);
    wr(8'h00, 32'h0000_8000);
    count_pulses(16, p);
    wr(8'h1C, 32'h0000_8100);
    count_pulses(40, q);
    chk("R10 refresh suppresses old match", p + q, 0);
    count_pulses(250, p);
    chk("R10 fires at refreshed value", p, 1);
    wr(8'h28, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h24, 32'h15);
    wr(8'h08, 32'h1234_5678);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h09, 32'hDEAD_BEEF);
    rd(8'h3C, v); chk("R11 unmapped read zero", v, 0);
    rd(8'h04, v); chk("R11 gap read zero", v, 0);
    rd(8'h09, v); chk("R11 unaligned read zero", v, 0);
    rd(8'h08, v); chk("R11 unaligned write ignored", v, 32'h1234_5678);
    rd(8'h24, v); chk("R11 enable unchanged", v, 32'h15);
    rd(8'h28, v); chk("R11 wd enable unchanged", v, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_counter();
    t_snapshot();
    t_match_rw();
    t_status_irq();
    t_wrap();
    t_wdog_gate();
    t_wdog_fire();
    t_refresh();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule